// File: doc/BRIEF.md
# Snooping Five-State Cache Line Controller

This block keeps the coherence state, tag and one data word for each line of a small direct-mapped cache. Several identical copies share one broadcast bus. A processor read or write that hits a line with enough permission finishes without any bus traffic. Otherwise the controller raises a bus request and issues one of four commands when it is granted: read, read-for-ownership, upgrade (invalidate other copies) or write-back. The same controller watches every command another cache puts on the bus. It then demotes or invalidates its own copy of the line, reports that it holds the line, and supplies the data when its copy is dirty.

Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. Owned marks the single dirty copy among several sharers. The Owned cache answers other caches' read misses in place of memory, and memory is updated only when that line is evicted. The processor side holds `cpu_req` and its fields steady until `cpu_done` pulses. The environment grants the bus to one cache per cycle and shows that cache's command to all the other caches as a snoop in the same cycle. The environment also combines the snoop responses: the shared flag, and the supplied data, which takes the place of memory data.

The controller FSM has three states. C_IDLE accepts a request. A hit with enough permission goes from C_IDLE to C_DONE. Any access that needs the bus goes from C_IDLE to C_BUS. C_BUS loops on itself after a granted write-back. It goes to C_DONE after a granted read, read-for-ownership or upgrade. C_DONE always returns to C_IDLE.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_done` and `bus_req` are low. The first access to any address after reset goes to the bus.
- R2: A read miss issues command 1 (read). When no other cache asserts shared, the line is filled Exclusive, and a later write to it completes with no bus transaction.
- R3: A read miss that sees shared asserted fills the line Shared. A write that hits a Shared or Owned line issues exactly one command 3 (upgrade) and completes.
- R4: On a snooped read, a Modified line asserts shared, supplies its data and becomes Owned. An Owned line keeps supplying on later snooped reads, and memory is not written.
- R5: A snooped read-for-ownership or upgrade that hits a line makes it Invalid, so the next local access to that address goes to the bus.
- R6: A write miss issues command 2 (read-for-ownership) and leaves the line Modified with the written data.
- R7: A miss whose victim line is Modified or Owned first issues command 4 (write-back) with the victim's address and data, then the fill. Shared or Exclusive victims are dropped silently. The address splits into index = low IDX_W bits and tag = the remaining bits.
- R8: A hit with enough permission raises `cpu_done` for exactly one cycle, one clock edge after the request is accepted.
- R9: Across two caches on one bus, every read returns the value of the most recent write to that address by either cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (index low, tag high) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted this cycle; the command takes effect |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Address of the command |
| bus_wdata | output | DATA_W | Write-back data |
| bus_shared_in | input | 1 | Another cache holds the line |
| bus_rdata_in | input | DATA_W | Fill data from a supplying cache or memory |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the data for the snooped line |
| snp_data | output | DATA_W | Supplied data |

## Verification
A hit accepted at one edge raises `cpu_done` after that edge. A bus command takes effect at the edge where it is granted, and the completion pulse follows one cycle later. Snoop responses are combinational in the cycle of the snooped command. The bench sets each request at a falling edge and samples `cpu_done` and `cpu_rdata` only at falling edges. It counts grants and supplied responses at rising edges, inside the window between request and completion, so every expected value is compared in the half-cycle after the edge that produced it. A table of directed operations fixes the expected data, the number of own bus commands, the last command and the supply flag for each step. A random sequential phase then checks every read against a reference copy of memory.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        L_I = 3'd0,
        L_S = 3'd1,
        L_E = 3'd2,
        L_O = 3'd3,
        L_M = 3'd4
    } line_state_t;

    typedef enum logic [2:0] {
        B_NONE = 3'd0,
        B_RD   = 3'd1,
        B_RDX  = 3'd2,
        B_UPG  = 3'd3,
        B_WB   = 3'd4
    } bus_cmd_t;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_BUS  = 2'd1,
        C_DONE = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lc_en,
    input  logic [IDX_W-1:0]  lc_idx,
    input  line_state_t       lc_state,
    input  logic [TAG_W-1:0]  lc_tag,
    input  logic              lc_data_en,
    input  logic [DATA_W-1:0] lc_data,
    input  logic              sn_en,
    input  logic [IDX_W-1:0]  sn_idx,
    input  line_state_t       sn_state,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_state_t       rd_state,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  sq_idx,
    output line_state_t       sq_state,
    output logic [TAG_W-1:0]  sq_tag,
    output logic [DATA_W-1:0] sq_data
);
    localparam int LINES = 1 << IDX_W;

    line_state_t [LINES-1:0]             st_all;
    logic        [LINES-1:0][TAG_W-1:0]  tag_all;
    logic        [LINES-1:0][DATA_W-1:0] dat_all;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_t       st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;
        logic              lc_sel;
        logic              sn_sel;

        assign lc_sel = lc_en && (lc_idx == IDX_W'(g));
        assign sn_sel = sn_en && (sn_idx == IDX_W'(g));

        // local update wins; the controller never overlaps it with a snoop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= L_I;
                tag_r <= '0;
                dat_r <= '0;
            end else if (lc_sel) begin
                st_r  <= lc_state;
                tag_r <= lc_tag;
                if (lc_data_en) dat_r <= lc_data;
            end else if (sn_sel) begin
                st_r <= sn_state;
            end
        end

        assign st_all[g]  = st_r;
        assign tag_all[g] = tag_r;
        assign dat_all[g] = dat_r;
    end

    assign rd_state = st_all[rd_idx];
    assign rd_tag   = tag_all[rd_idx];
    assign rd_data  = dat_all[rd_idx];
    assign sq_state = st_all[sq_idx];
    assign sq_tag   = tag_all[sq_idx];
    assign sq_data  = dat_all[sq_idx];

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
    import moesi_pkg::*;
(
    input  logic        valid,
    input  bus_cmd_t    cmd,
    input  logic        hit,
    input  line_state_t cur,
    output logic        upd,
    output line_state_t nxt,
    output logic        shared,
    output logic        supply
);
    logic dirty;
    assign dirty = (cur == L_M) || (cur == L_O);

    always_comb begin
        upd    = 1'b0;
        nxt    = cur;
        shared = 1'b0;
        supply = 1'b0;
        if (valid && hit) begin
            unique case (cmd)
                B_RD: begin
                    shared = 1'b1;
                    supply = dirty;
                    if (cur == L_M) begin
                        upd = 1'b1;
                        nxt = L_O;
                    end else if (cur == L_E) begin
                        upd = 1'b1;
                        nxt = L_S;
                    end
                end
                B_RDX: begin
                    shared = 1'b1;
                    supply = dirty;
                    upd    = 1'b1;
                    nxt    = L_I;
                end
                B_UPG: begin
                    shared = 1'b1;
                    upd    = 1'b1;
                    nxt    = L_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata_in,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_t        cur_c, nxt_c;
    logic [IDX_W-1:0]  idx, s_idx;
    logic [TAG_W-1:0]  tag, s_tag;
    line_state_t       ln_state, sq_state, sn_state;
    logic [TAG_W-1:0]  ln_tag, sq_tag;
    logic [DATA_W-1:0] ln_data, sq_data;
    logic              tag_hit, ln_dirty, clash, sn_hit, sn_upd;
    bus_cmd_t          need;

    logic              lc_en, lc_data_en;
    line_state_t       lc_state;
    logic [TAG_W-1:0]  lc_tag;
    logic [DATA_W-1:0] lc_data;

    assign idx   = cpu_addr[IDX_W-1:0];
    assign tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    moesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lc_en      (lc_en),
        .lc_idx     (idx),
        .lc_state   (lc_state),
        .lc_tag     (lc_tag),
        .lc_data_en (lc_data_en),
        .lc_data    (lc_data),
        .sn_en      (sn_upd),
        .sn_idx     (s_idx),
        .sn_state   (sn_state),
        .rd_idx     (idx),
        .rd_state   (ln_state),
        .rd_tag     (ln_tag),
        .rd_data    (ln_data),
        .sq_idx     (s_idx),
        .sq_state   (sq_state),
        .sq_tag     (sq_tag),
        .sq_data    (sq_data)
    );

    assign sn_hit = (sq_state != L_I) && (sq_tag == s_tag);

    moesi_snoop_resp u_snoop (
        .valid  (snp_valid),
        .cmd    (bus_cmd_t'(snp_cmd)),
        .hit    (sn_hit),
        .cur    (sq_state),
        .upd    (sn_upd),
        .nxt    (sn_state),
        .shared (snp_shared),
        .supply (snp_supply)
    );
    assign snp_data = sq_data;

    // command the pending access still needs, re-evaluated every cycle
    assign tag_hit  = (ln_state != L_I) && (ln_tag == tag);
    assign ln_dirty = (ln_state == L_M) || (ln_state == L_O);
    assign clash    = snp_valid && (s_idx == idx);

    always_comb begin
        if (!tag_hit && ln_dirty)                            need = B_WB;
        else if (!tag_hit)                                   need = cpu_we ? B_RDX : B_RD;
        else if (cpu_we && (ln_state == L_S || ln_state == L_O)) need = B_UPG;
        else                                                 need = B_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_c <= C_IDLE;
        else        cur_c <= nxt_c;
    end

    always_comb begin
        nxt_c      = cur_c;
        cpu_done   = 1'b0;
        bus_req    = 1'b0;
        bus_cmd    = B_NONE;
        bus_addr   = cpu_addr;
        bus_wdata  = ln_data;
        lc_en      = 1'b0;
        lc_state   = ln_state;
        lc_tag     = tag;
        lc_data_en = 1'b0;
        lc_data    = cpu_wdata;
        unique case (cur_c)
            C_IDLE: begin
                if (cpu_req) begin
                    if (need != B_NONE) begin
                        nxt_c = C_BUS;
                    end else if (!clash) begin
                        nxt_c = C_DONE;
                        if (cpu_we) begin
                            lc_en      = 1'b1;
                            lc_state   = L_M;
                            lc_data_en = 1'b1;
                        end
                    end
                end
            end
            C_BUS: begin
                bus_req = 1'b1;
                bus_cmd = need;
                if (need == B_WB) bus_addr = {ln_tag, idx};
                if (need == B_NONE) begin
                    nxt_c = C_DONE;
                end else if (bus_gnt) begin
                    lc_en = 1'b1;
                    unique case (need)
                        B_WB: begin
                            lc_state = L_I;
                            lc_tag   = ln_tag;
                        end
                        B_RD: begin
                            lc_state   = bus_shared_in ? L_S : L_E;
                            lc_data_en = 1'b1;
                            lc_data    = bus_rdata_in;
                            nxt_c      = C_DONE;
                        end
                        default: begin
                            lc_state   = L_M;
                            lc_data_en = 1'b1;
                            nxt_c      = C_DONE;
                        end
                    endcase
                end
            end
            C_DONE: begin
                cpu_done = 1'b1;
                nxt_c    = C_IDLE;
            end
            default: nxt_c = C_IDLE;
        endcase
    end

    assign cpu_rdata = ln_data;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_done,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [2:0] bus_cmd,
    input logic       snp_valid,
    input logic       snp_shared,
    input logic       snp_supply,
    input logic [2:0] ln_state
);
    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R4: a supplying cache always reports that it holds the line
    p_supply_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);

    // R6: a request always carries a real command
    p_req_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 3'd0));

    // R7: no fill is issued while the victim line is still dirty
    p_wb_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_cmd == 3'd1 || bus_cmd == 3'd2)) |-> !(ln_state == 3'd3 || ln_state == 3'd4));

    // R2: a granted fill or upgrade completes on the next cycle
    p_fill_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd != 3'd4) |=> cpu_done);

    // R9: a cache never snoops its own granted command
    p_no_self_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_req && bus_gnt));

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .snp_valid  (snp_valid),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply),
    .ln_state   (ln_state)
);

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 2;
    localparam int NVEC       = 18;
    localparam int MAXCYC     = 100000;
    localparam int NADDR      = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              req_a = 0, we_a = 0, req_b = 0, we_b = 0;
    logic [ADDR_W-1:0] ad_a = 0, ad_b = 0;
    logic [DATA_W-1:0] wd_a = 0, wd_b = 0;
    logic              done_a, done_b, breq_a, breq_b, gnt_a, gnt_b;
    logic              sh_a, sh_b, sup_a, sup_b;
    logic [2:0]        cmd_a, cmd_b;
    logic [ADDR_W-1:0] baddr_a, baddr_b;
    logic [DATA_W-1:0] rd_a, rd_b, bwd_a, bwd_b, sdat_a, sdat_b, fill_a, fill_b;

    logic [DATA_W-1:0] mem  [NADDR];
    logic [DATA_W-1:0] gold [NADDR];

    assign gnt_a  = breq_a;
    assign gnt_b  = breq_b && !breq_a;
    assign fill_a = sup_b ? sdat_b : mem[baddr_a];
    assign fill_b = sup_a ? sdat_a : mem[baddr_b];

    moesi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_moesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req_a), .cpu_we(we_a), .cpu_addr(ad_a), .cpu_wdata(wd_a),
        .cpu_done(done_a), .cpu_rdata(rd_a),
        .bus_req(breq_a), .bus_gnt(gnt_a), .bus_cmd(cmd_a), .bus_addr(baddr_a),
        .bus_wdata(bwd_a), .bus_shared_in(sh_b), .bus_rdata_in(fill_a),
        .snp_valid(gnt_b), .snp_cmd(cmd_b), .snp_addr(baddr_b),
        .snp_shared(sh_a), .snp_supply(sup_a), .snp_data(sdat_a)
    );

    moesi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_moesi_line_ctrl_peer (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req_b), .cpu_we(we_b), .cpu_addr(ad_b), .cpu_wdata(wd_b),
        .cpu_done(done_b), .cpu_rdata(rd_b),
        .bus_req(breq_b), .bus_gnt(gnt_b), .bus_cmd(cmd_b), .bus_addr(baddr_b),
        .bus_wdata(bwd_b), .bus_shared_in(sh_a), .bus_rdata_in(fill_b),
        .snp_valid(gnt_a), .snp_cmd(cmd_a), .snp_addr(baddr_a),
        .snp_shared(sh_b), .snp_supply(sup_b), .snp_data(sdat_b)
    );

    // memory model and per-operation bus monitor
    logic       mon_clr = 1'b0;
    int         ntx_a, ntx_b;
    logic [2:0] last_a, last_b;
    logic       got_a, got_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NADDR; i++) mem[i] <= DATA_W'(i * 3 + 1);
        end else begin
            if (gnt_a && cmd_a == 3'd4) mem[baddr_a] <= bwd_a;
            if (gnt_b && cmd_b == 3'd4) mem[baddr_b] <= bwd_b;
        end
        if (mon_clr) begin
            ntx_a <= 0; ntx_b <= 0; last_a <= 3'd0; last_b <= 3'd0;
            got_a <= 1'b0; got_b <= 1'b0;
        end else begin
            if (gnt_a) begin
                ntx_a <= ntx_a + 1; last_a <= cmd_a;
                if (sup_b) got_a <= 1'b1;
            end
            if (gnt_b) begin
                ntx_b <= ntx_b + 1; last_b <= cmd_b;
                if (sup_a) got_b <= 1'b1;
            end
        end
    end

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic gold_init();
        for (int i = 0; i < NADDR; i++) gold[i] = DATA_W'(i * 3 + 1);
    endtask

    task automatic run_op(input logic who, input logic we, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] wd, input int rq, output logic [DATA_W-1:0] rd);
        logic hung;
        @(negedge clk);
        if (who) begin req_b = 1; we_b = we; ad_b = addr; wd_b = wd; end
        else     begin req_a = 1; we_a = we; ad_a = addr; wd_a = wd; end
        mon_clr = 1'b1;
        hung = 1'b1;
        rd = '0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            mon_clr = 1'b0;
            if (who ? done_b : done_a) begin
                rd = who ? rd_b : rd_a;
                hung = 1'b0;
                break;
            end
        end
        req_a = 0; req_b = 0;
        nchk++;
        if (hung) begin
            nerr++;
            $display("FAIL R%0d operation timeout: actual no done expected done", rq);
        end else if (we) begin
            gold[addr] = wd;
        end
    endtask

    // {who, we, addr[6], wdata[8], exp_rdata[8], own_cmds[2], last_cmd[3], supplied[1]}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'h05, 8'h00, 8'd16,  2'd1, 3'd1, 1'b0}, // R1 R2 read miss fills Exclusive
        {1'b0, 1'b1, 6'h05, 8'hA1, 8'h00,  2'd0, 3'd0, 1'b0}, // R2 silent write on Exclusive
        {1'b1, 1'b0, 6'h05, 8'h00, 8'hA1,  2'd1, 3'd1, 1'b1}, // R4 Modified supplies, goes Owned
        {1'b1, 1'b0, 6'h05, 8'h00, 8'hA1,  2'd0, 3'd0, 1'b0}, // R8 Shared read hit
        {1'b0, 1'b0, 6'h05, 8'h00, 8'hA1,  2'd0, 3'd0, 1'b0}, // R8 Owned read hit
        {1'b1, 1'b1, 6'h05, 8'hB2, 8'h00,  2'd1, 3'd3, 1'b0}, // R3 upgrade from Shared
        {1'b0, 1'b0, 6'h05, 8'h00, 8'hB2,  2'd1, 3'd1, 1'b1}, // R5 invalidated copy misses
        {1'b1, 1'b0, 6'h09, 8'h00, 8'd28,  2'd2, 3'd1, 1'b0}, // R7 Owned victim written back
        {1'b0, 1'b0, 6'h09, 8'h00, 8'd28,  2'd1, 3'd1, 1'b0}, // R7 Shared victim dropped
        {1'b0, 1'b0, 6'h0D, 8'h00, 8'd40,  2'd1, 3'd1, 1'b0}, // R7 Shared victim dropped
        {1'b0, 1'b0, 6'h05, 8'h00, 8'hB2,  2'd1, 3'd1, 1'b0}, // R7 memory holds written-back data
        {1'b0, 1'b1, 6'h02, 8'h33, 8'h00,  2'd1, 3'd2, 1'b0}, // R6 write miss
        {1'b1, 1'b0, 6'h02, 8'h00, 8'h33,  2'd1, 3'd1, 1'b1}, // R4 Modified supplies
        {1'b1, 1'b1, 6'h0A, 8'h55, 8'h00,  2'd1, 3'd2, 1'b0}, // R6 write miss over Shared victim
        {1'b0, 1'b1, 6'h0A, 8'h44, 8'h00,  2'd2, 3'd2, 1'b1}, // R7 write-back then ownership
        {1'b1, 1'b0, 6'h0A, 8'h00, 8'h44,  2'd1, 3'd1, 1'b1}, // R5 invalidated by ownership
        {1'b1, 1'b0, 6'h02, 8'h00, 8'h33,  2'd1, 3'd1, 1'b0}, // R7 memory updated by write-back
        {1'b1, 1'b0, 6'h0A, 8'h00, 8'h44,  2'd1, 3'd1, 1'b1}  // R4 Owned keeps supplying
    };
    localparam int VREQ [NVEC] = '{2, 2, 4, 8, 8, 3, 5, 7, 7, 7, 7, 6, 4, 6, 7, 5, 7, 4};

    initial begin
        repeat (MAXCYC) @(posedge clk);
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        logic [29:0]       v;
        gold_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(1, "done after reset (A)", {31'd0, done_a}, 32'd0);
        chk(1, "done after reset (B)", {31'd0, done_b}, 32'd0);
        chk(1, "bus_req after reset (A)", {31'd0, breq_a}, 32'd0);
        chk(1, "bus_req after reset (B)", {31'd0, breq_b}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            run_op(v[29], v[28], v[27:22], v[21:14], VREQ[i], rd);
            if (!v[28]) chk(VREQ[i], $sformatf("step %0d read data", i), {24'd0, rd}, {24'd0, v[13:6]});
            chk(VREQ[i], $sformatf("step %0d own bus commands", i), v[29] ? ntx_b : ntx_a, {30'd0, v[5:4]});
            if (v[5:4] != 2'd0)
                chk(VREQ[i], $sformatf("step %0d last command", i), {29'd0, v[29] ? last_b : last_a}, {29'd0, v[3:1]});
            chk(VREQ[i], $sformatf("step %0d data supplied by peer", i), {31'd0, v[29] ? got_b : got_a}, {31'd0, v[0]});
        end

        // R8: pulse lasts one cycle (sampled one cycle after a hit completes)
        run_op(1'b1, 1'b0, 6'h0A, 8'h00, 8, rd);
        @(negedge clk);
        chk(8, "done pulse ends", {31'd0, done_b}, 32'd0);

        // R1: reset drops every cached line
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        gold_init();
        run_op(1'b0, 1'b0, 6'h05, 8'h00, 1, rd);
        chk(1, "post-reset read data", {24'd0, rd}, 32'd16);
        chk(1, "post-reset access uses bus", ntx_a, 32'd1);
        chk(1, "post-reset command is read", {29'd0, last_a}, 32'd1);

        // R9: random sequential traffic on colliding indices
        for (int n = 0; n < 400; n++) begin
            logic              who, we;
            logic [ADDR_W-1:0] ad;
            logic [DATA_W-1:0] wd;
            logic [DATA_W-1:0] exp;
            who = 1'($urandom % 2);
            we  = (($urandom % 3) == 0);
            ad  = {2'b00, 4'($urandom % 16)};
            wd  = DATA_W'($urandom);
            exp = gold[ad];
            run_op(who, we, ad, wd, 9, rd);
            if (!we) chk(9, $sformatf("random read %0d addr %0h", n, ad), {24'd0, rd}, {24'd0, exp});
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule